// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is an integer arithmetic unit that holds a pair of W-bit result registers, HI and LO, which together form a 2W-bit value with HI as the upper half. A single-cycle multiplier supports signed and unsigned products. It can also add the product to the HI:LO pair or subtract it from the pair. A restoring divider works one quotient bit per cycle and writes the quotient to LO and the remainder to HI.

An operation is issued by raising `op_valid` for one cycle with a code on `op_code` and two operands. Software-style direct writes to HI or LO use `hi_we`/`lo_we` with `wr_data`. While a divide is in progress `busy` is high and further operation requests are dropped. A one-cycle `done` pulse marks the divide result.

Top module: `muldiv_hilo`

## Requirements
- R1: Code 0x1 (signed multiply), when accepted, sign-extends both operands and writes the 2W-bit product to HI:LO. LO takes bits W-1:0 and HI takes bits 2W-1:W. The result is visible in the cycle after the issuing edge.
- R2: Code 0x2 (unsigned multiply) does the same with both operands zero-extended.
- R3: Codes 0x3 (signed) and 0x4 (unsigned) write HI:LO plus the product back to HI:LO, modulo 2^(2W), in the cycle after issue.
- R4: Codes 0x5 (signed) and 0x6 (unsigned) write HI:LO minus the product back to HI:LO, modulo 2^(2W), in the cycle after issue.
- R5: Codes 0x8 (signed) and 0x9 (unsigned) divide opa by opb and write the quotient to LO and the remainder to HI. The signed quotient truncates toward zero, and the remainder takes the sign of the dividend.
- R6: An accepted divide with a nonzero divisor raises `busy` for exactly W+1 cycles, starting in the cycle after the issuing edge. `done` is high for exactly one cycle, the first cycle with `busy` low, and HI/LO hold the result from that same cycle.
- R7: A request (`op_valid`) made while `busy` is high is ignored. It neither changes HI/LO nor alters the running divide.
- R8: A divide with opb equal to zero leaves HI and LO unchanged, does not raise `busy`, and sets `div_by_zero`. That flag then stays high until reset.
- R9: A signed divide of the most negative value by -1 gives LO equal to the dividend and HI equal to 0.
- R10: `hi_we`/`lo_we` load `wr_data` into HI/LO, visible in the next cycle. If a multiply is accepted in the same cycle, or a divide completes in that cycle, the operation result wins over the direct write.
- R11: After reset, HI, LO, `busy`, `done` and `div_by_zero` are all zero.
- R12: An accepted request whose code is not one of 0x1-0x6, 0x8 or 0x9 has no effect on HI, LO or `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request, one cycle |
| op_code | input | 4 | Operation code |
| opa | input | W | First operand / dividend |
| opb | input | W | Second operand / divisor |
| hi_we | input | 1 | Direct write enable for HI |
| lo_we | input | 1 | Direct write enable for LO |
| wr_data | input | W | Data for direct writes |
| hi_out | output | W | HI register |
| lo_out | output | W | LO register |
| busy | output | 1 | Divide in progress |
| done | output | 1 | Divide result pulse |
| div_by_zero | output | 1 | Sticky divide-by-zero flag |

## Verification
Multiply, accumulate, subtract, direct-write and ignored-code results are all due one cycle after the issuing edge. The bench drives each request on a falling edge and reads the outputs on the next falling edge. A divide result, and the done pulse with it, is due W+1 cycles after the issuing edge. For each divide the bench counts falling edges, checks `busy` on every intermediate one, and reads the result on exactly the (W+1)th. A divide-by-zero, or a request dropped while busy, is checked on the falling edge right after the request, before anything else can change HI or LO.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W   = 32,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic           hi_we,
  input  logic           lo_we,
  input  logic [W-1:0]   wr_data,
  output logic [W-1:0]   hi_out,
  output logic [W-1:0]   lo_out,
  output logic           busy,
  output logic           done,
  output logic           div_by_zero
);
  localparam int CW = $clog2(W + 1);
  localparam logic [OPW-1:0] C_MULS = 1, C_MULU = 2, C_MADS = 3, C_MADU = 4,
                             C_MSBS = 5, C_MSBU = 6, C_DIVS = 8, C_DIVU = 9;

  logic [W-1:0]  hi_q, lo_q, quo_q, dvs_q, rem_q;
  logic          busy_q, setup_q, done_q, dbz_q, aneg_q, bneg_q;
  logic [CW-1:0] cnt_q;

  wire accept  = op_valid & ~busy_q;
  wire sgn     = (op_code == C_MULS) | (op_code == C_MADS) |
                 (op_code == C_MSBS) | (op_code == C_DIVS);
  wire is_mul  = (op_code == C_MULS) | (op_code == C_MULU) | (op_code == C_MADS) |
                 (op_code == C_MADU) | (op_code == C_MSBS) | (op_code == C_MSBU);
  wire is_div  = (op_code == C_DIVS) | (op_code == C_DIVU);

  wire [W:0] ext_a = {sgn & opa[W-1], opa};
  wire [W:0] ext_b = {sgn & opb[W-1], opb};
  logic signed [2*W+1:0] prod;
  assign prod = $signed(ext_a) * $signed(ext_b);

  wire [2*W-1:0] hilo = {hi_q, lo_q};
  logic [2*W-1:0] mul_res;
  always_comb begin
    case (op_code)
      C_MADS, C_MADU: mul_res = hilo + prod[2*W-1:0];
      C_MSBS, C_MSBU: mul_res = hilo - prod[2*W-1:0];
      default:        mul_res = prod[2*W-1:0];
    endcase
  end

  wire [W:0]   shifted = {rem_q, quo_q[W-1]};
  wire [W:0]   diff    = shifted - {1'b0, dvs_q};
  wire         take    = ~diff[W];
  wire [W-1:0] rem_nx  = take ? diff[W-1:0] : shifted[W-1:0];
  wire [W-1:0] quo_nx  = {quo_q[W-2:0], take};
  wire         last    = busy_q & ~setup_q & (cnt_q == CW'(1));
  wire [W-1:0] q_fin   = (aneg_q ^ bneg_q) ? -quo_nx : quo_nx;
  wire [W-1:0] r_fin   = aneg_q ? -rem_nx : rem_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0; lo_q <= '0; quo_q <= '0; dvs_q <= '0; rem_q <= '0;
      busy_q <= 1'b0; setup_q <= 1'b0; done_q <= 1'b0; dbz_q <= 1'b0;
      aneg_q <= 1'b0; bneg_q <= 1'b0; cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (last) begin
        hi_q <= r_fin;
        lo_q <= q_fin;
      end else if (accept && is_mul) begin
        hi_q <= mul_res[2*W-1:W];
        lo_q <= mul_res[W-1:0];
      end else begin
        if (hi_we) hi_q <= wr_data;
        if (lo_we) lo_q <= wr_data;
      end

      if (accept && is_div) begin
        if (opb == '0) begin
          dbz_q <= 1'b1;
        end else begin
          busy_q  <= 1'b1;
          setup_q <= 1'b1;
          quo_q   <= opa;
          dvs_q   <= opb;
          aneg_q  <= sgn & opa[W-1];
          bneg_q  <= sgn & opb[W-1];
        end
      end else if (busy_q && setup_q) begin
        setup_q <= 1'b0;
        quo_q   <= aneg_q ? -quo_q : quo_q;
        dvs_q   <= bneg_q ? -dvs_q : dvs_q;
        rem_q   <= '0;
        cnt_q   <= CW'(W);
      end else if (busy_q) begin
        quo_q <= quo_nx;
        rem_q <= rem_nx;
        cnt_q <= cnt_q - CW'(1);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign hi_out      = hi_q;
  assign lo_out      = lo_q;
  assign busy        = busy_q;
  assign done        = done_q;
  assign div_by_zero = dbz_q;
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W   = 32,
  parameter int OPW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic [OPW-1:0] op_code,
  input logic [W-1:0]   opa,
  input logic [W-1:0]   opb,
  input logic           hi_we,
  input logic           lo_we,
  input logic [W-1:0]   hi_out,
  input logic [W-1:0]   lo_out,
  input logic           busy,
  input logic           done,
  input logic           div_by_zero
);
  localparam int BW = $clog2(W + 3);
  logic signed [2*W-1:0] ea, eb, sprod;
  assign ea = $signed(opa);
  assign eb = $signed(opb);
  assign sprod = ea * eb;

  logic [BW-1:0] bcnt;
  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= '0;
    else if (busy) bcnt <= bcnt + BW'(1);
    else bcnt <= '0;
  end

  p_mul_signed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_code == OPW'(1)) |=> ({hi_out, lo_out} == $past(sprod)));

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == BW'(W + 1)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hi_we && !lo_we) |=> (done || ($stable(hi_out) && $stable(lo_out))));

  p_dbz_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    div_by_zero |=> div_by_zero);

  p_dbz_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && (op_code == OPW'(8) || op_code == OPW'(9)) && opb == '0
     && !hi_we && !lo_we) |=> (!busy && div_by_zero && $stable(hi_out) && $stable(lo_out)));
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .opa(opa), .opb(opb), .hi_we(hi_we), .lo_we(lo_we),
  .hi_out(hi_out), .lo_out(lo_out), .busy(busy), .done(done),
  .div_by_zero(div_by_zero)
);

// File: tb/muldiv_hilo_tb.sv
module muldiv_hilo_tb;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0, hi_we = 1'b0, lo_we = 1'b0;
  logic [3:0] op_code = '0;
  logic [W-1:0] opa = '0, opb = '0, wr_data = '0;
  logic [W-1:0] hi_out, lo_out;
  logic busy, done, div_by_zero;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  muldiv_hilo u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opa(opa), .opb(opb), .hi_we(hi_we), .lo_we(lo_we), .wr_data(wr_data),
    .hi_out(hi_out), .lo_out(lo_out), .busy(busy), .done(done),
    .div_by_zero(div_by_zero)
  );

  logic [W-1:0] vals [8] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h80000000,
                             32'h7FFFFFFF, 32'h7, 32'hFFFFFFF3, 32'h12345678};

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic preload(input logic [63:0] v);
    @(negedge clk); hi_we = 1'b1; wr_data = v[63:32];
    @(negedge clk); hi_we = 1'b0; lo_we = 1'b1; wr_data = v[31:0];
    @(negedge clk); lo_we = 1'b0;
  endtask

  task automatic issue(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk); op_valid = 1'b1; op_code = c; opa = a; opb = b;
    @(negedge clk); op_valid = 1'b0;
  endtask

  task automatic run_div(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                         input string r);
    int nb;
    longint q, m;
    issue(c, a, b);
    nb = 0;
    for (int k = 0; k < W; k++) begin
      if (busy) nb++;
      @(negedge clk);
    end
    if (busy) nb++;
    @(negedge clk);
    if (c == 4'h8) begin
      q = longint'($signed(a)) / longint'($signed(b));
      m = longint'($signed(a)) % longint'($signed(b));
    end else begin
      q = longint'({32'b0, a}) / longint'({32'b0, b});
      m = longint'({32'b0, a}) % longint'({32'b0, b});
    end
    chk(r, {hi_out, lo_out}, {m[31:0], q[31:0]});
    chk("R6 busy cycles", 64'(nb), 64'(W + 1));
    chk("R6 done/busy at result", {62'b0, done, busy}, 64'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint p;
    logic [63:0] base;
    do_reset();
    @(negedge clk);
    // R11
    chk("R11 reset", {hi_out, lo_out}, 64'h0);
    chk("R11 reset flags", {61'b0, busy, done, div_by_zero}, 64'h0);

    // R10 direct writes
    preload(64'hDEADBEEF_CAFEF00D);
    chk("R10 direct write", {hi_out, lo_out}, 64'hDEADBEEF_CAFEF00D);

    // R1, R2
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        issue(4'h1, vals[i], vals[j]);
        p = longint'($signed(vals[i])) * longint'($signed(vals[j]));
        chk("R1 signed mul", {hi_out, lo_out}, p);
        issue(4'h2, vals[i], vals[j]);
        p = longint'({32'b0, vals[i]}) * longint'({32'b0, vals[j]});
        chk("R2 unsigned mul", {hi_out, lo_out}, p);
      end

    // R3, R4
    for (int i = 0; i < 8; i++) begin
      base = 64'h01234567_89ABCDEF ^ {32'(i * 3), 32'hF0F0F0F0 ^ 32'(i)};
      preload(base);
      issue(4'h3, vals[i], vals[7-i]);
      p = longint'($signed(vals[i])) * longint'($signed(vals[7-i]));
      chk("R3 signed madd", {hi_out, lo_out}, base + p);
      preload(base);
      issue(4'h4, vals[i], vals[7-i]);
      p = longint'({32'b0, vals[i]}) * longint'({32'b0, vals[7-i]});
      chk("R3 unsigned madd", {hi_out, lo_out}, base + p);
      preload(base);
      issue(4'h5, vals[i], vals[7-i]);
      p = longint'($signed(vals[i])) * longint'($signed(vals[7-i]));
      chk("R4 signed msub", {hi_out, lo_out}, base - p);
      preload(base);
      issue(4'h6, vals[i], vals[7-i]);
      p = longint'({32'b0, vals[i]}) * longint'({32'b0, vals[7-i]});
      chk("R4 unsigned msub", {hi_out, lo_out}, base - p);
    end

    // R5, R6, R9
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        if (vals[j] != 0) begin
          if (vals[i] == 32'h80000000 && vals[j] == 32'hFFFFFFFF)
            run_div(4'h8, vals[i], vals[j], "R9 min by -1");
          else
            run_div(4'h8, vals[i], vals[j], "R5 signed div");
          run_div(4'h9, vals[i], vals[j], "R5 unsigned div");
        end
    @(negedge clk);
    chk("R6 done one cycle", {63'b0, done}, 64'h0);
    chk("R9 explicit", 64'({32'h0, 32'h80000000}), 64'(longint'(-64'sd2147483648) / -1) & 64'hFFFFFFFF);

    // R7 requests while busy
    preload(64'h11112222_33334444);
    issue(4'h9, 32'd100, 32'd7);
    @(negedge clk); op_valid = 1'b1; op_code = 4'h1; opa = 32'd5; opb = 32'd5;
    @(negedge clk); op_valid = 1'b1; op_code = 4'h8; opa = 32'd9; opb = 32'd2;
    chk("R7 mul ignored while busy", {hi_out, lo_out}, 64'h11112222_33334444);
    @(negedge clk); op_valid = 1'b0;
    chk("R7 div ignored while busy", {hi_out, lo_out}, 64'h11112222_33334444);
    repeat (W - 2) @(negedge clk);
    chk("R7 running divide intact", {hi_out, lo_out, 31'b0, done}, {32'd2, 32'd14, 32'd1});

    // R10 priority
    @(negedge clk); hi_we = 1'b1; lo_we = 1'b1; wr_data = 32'hA5A5A5A5;
    op_valid = 1'b1; op_code = 4'h1; opa = 32'd2; opb = 32'd3;
    @(negedge clk); hi_we = 1'b0; lo_we = 1'b0; op_valid = 1'b0;
    chk("R10 mul beats write", {hi_out, lo_out}, 64'd6);

    // R12 undefined codes
    preload(64'h0BAD0BAD_600D600D);
    issue(4'h7, 32'd3, 32'd3);
    chk("R12 code 7", {hi_out, lo_out, 31'b0, busy}, {64'h0BAD0BAD_600D600D, 32'd0});
    issue(4'hF, 32'd3, 32'd3);
    chk("R12 code F", {hi_out, lo_out, 31'b0, busy}, {64'h0BAD0BAD_600D600D, 32'd0});

    // R8 divide by zero
    chk("R8 flag clear before", {63'b0, div_by_zero}, 64'h0);
    issue(4'h8, 32'd9, 32'd0);
    chk("R8 hilo unchanged", {hi_out, lo_out}, 64'h0BAD0BAD_600D600D);
    chk("R8 flag set, not busy", {62'b0, div_by_zero, busy}, 64'b10);
    issue(4'h1, 32'd3, 32'd4);
    chk("R8 flag sticky", {31'b0, div_by_zero, lo_out}, {32'd1, 32'd12});
    do_reset();
    @(negedge clk);
    chk("R11 reset clears flag", {63'b0, div_by_zero}, 64'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule